// File: doc/BRIEF.md
# Serial Byte Receiver with Mid-Cell Phase Alignment

This block takes an asynchronous serial input line and turns each frame on it into a byte held for the CPU. A frame is one low start cell, then eight data cells with the least significant bit first, then a stop cell. The input is resynchronised first. While the block is idle, the line is checked on every system clock for a low level. When that low level is seen, the bit-period divider is preset to half its period. Its later ticks then land near the middle of each cell, and one sample is taken per tick.

When the last tick of a frame arrives, the assembled byte is copied into the receive buffer. A ready flag is set and a one-cycle interrupt request pulse is issued. The pulse is meant to set a bit in a sticky interrupt status collector elsewhere in the chip. A CPU read of the buffer, signalled by a one-cycle read strobe, clears the ready flag. The flag is intended to appear as one bit of the CPU-visible status word.

The clocks per bit are CLK_HZ / BAUD, written BIT_CLKS below. The defaults, 50 MHz and 9600 baud, give 5208.

Top module: `serial_rx_align`

## Requirements
- R1: While rst_n is low and after its release, rx_ready and irq_pulse are 0, rx_data is 0x00, and the receiver is idle.
- R2: rxd_in passes through a two-flop synchronizer. Count the first clock edge that samples rxd_in low while idle as edge 1. The frame then completes on edge 3 + (BIT_CLKS - BIT_CLKS/2) + 9*BIT_CLKS.
- R3: Data bit k (k = 0..7) is the rxd_in level seen at edge 1 + (BIT_CLKS - BIT_CLKS/2) + (k+1)*BIT_CLKS. It is stored in rx_data[k], so the first cell after the start cell becomes bit 0.
- R4: Between start detection and frame completion, the line is looked at only at the tick instants. Low levels or glitches elsewhere in a frame neither restart it nor alter the data.
- R5: rx_ready goes to 1 on the completion edge and stays 1 until a cycle with rd_strobe high, after which it is 0. A read strobe on the completion edge itself leaves rx_ready at 1.
- R6: irq_pulse is high for exactly one cycle per completed frame, in the first cycle that rx_ready shows the new frame.
- R7: rx_data changes only on a completion edge; it keeps the previous byte while the next frame is being received.
- R8: The stop cell level is not checked. A frame with a low stop cell still completes with its data. If the line is low once the receiver is idle again, that low is taken as a new start at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_in | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | One-cycle CPU read of the receive buffer |
| rx_data | output | 8 | Receive buffer, last completed byte |
| rx_ready | output | 1 | Data-ready flag (status bit) |
| irq_pulse | output | 1 | One-cycle interrupt request per received byte |

## Verification
A wrong sequencer state or bit count shows at the ports as a shifted completion edge for the frame. The irq_pulse then comes earlier or later than the R2 formula, and the error is visible within one frame of about ten bit periods. A divider that is off in phase or period moves the sample instants. With cell patterns that differ from their neighbours, this shows as a wrong rx_data byte on that same completion edge. Ready-flag errors appear within one cycle of a read strobe or a completion, which is why the reference model is compared with the ports on every clock.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  // Divider preset applied on start detection: half a bit period.
  function automatic int unsigned half_period(input int unsigned bit_clks);
    return bit_clks / 2;
  endfunction

  // Clocks from start detection to the first (mid start cell) tick.
  function automatic int unsigned first_tick_gap(input int unsigned bit_clks);
    return bit_clks - half_period(bit_clks);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rx_baud_gen.sv
module rx_baud_gen
  import serial_rx_pkg::*;
#(
  parameter int BIT_CLKS = 5208
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic tick
);
  localparam int CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] PRE  = CW'(half_period(BIT_CLKS));

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= PRE;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
  import serial_rx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_s,
  input  logic             tick,
  output logic             start_det,
  output logic             frame_done,
  output rx_state_t        state,
  output logic [NBITS-1:0] shift_q
);
  localparam int BCW = (NBITS > 2) ? $clog2(NBITS) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(NBITS - 1);

  logic [BCW-1:0] bit_cnt;

  assign start_det  = (state == RX_IDLE) && !rxd_s;
  assign frame_done = (state == RX_STOP) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      bit_cnt <= '0;
      shift_q <= '0;
    end else begin
      unique case (state)
        RX_IDLE:  if (start_det) state <= RX_START;
        RX_START: if (tick) begin
          state   <= RX_DATA;
          bit_cnt <= '0;
        end
        RX_DATA:  if (tick) begin
          shift_q <= {rxd_s, shift_q[NBITS-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) state <= RX_STOP;
        end
        RX_STOP:  if (tick) state <= RX_IDLE;
        default:  state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [NBITS-1:0] shift_in,
  input  logic             rd,
  output logic [NBITS-1:0] data,
  output logic             ready,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      ready <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (done) data <= shift_in;
      ready <= done | (ready & ~rd);
      irq   <= done;
    end
  end
endmodule

// File: rtl/serial_rx_align.sv
module serial_rx_align
  import serial_rx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 9600,
  parameter int NBITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_in,
  input  logic             rd_strobe,
  output logic [NBITS-1:0] rx_data,
  output logic             rx_ready,
  output logic             irq_pulse
);
  localparam int BIT_CLKS = CLK_HZ / BAUD;

  logic             rxd_s;
  logic             start_det;
  logic             baud_tick;
  logic             frame_done;
  rx_state_t        state;
  logic [NBITS-1:0] shift_q;

  rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd_in), .q(rxd_s)
  );

  rx_baud_gen #(.BIT_CLKS(BIT_CLKS)) u_baud (
    .clk(clk), .rst_n(rst_n), .load(start_det),
    .run(state != RX_IDLE), .tick(baud_tick)
  );

  rx_frame_seq #(.NBITS(NBITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .rxd_s(rxd_s), .tick(baud_tick),
    .start_det(start_det), .frame_done(frame_done),
    .state(state), .shift_q(shift_q)
  );

  rx_hold #(.NBITS(NBITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .shift_in(shift_q),
    .rd(rd_strobe), .data(rx_data), .ready(rx_ready), .irq(irq_pulse)
  );
endmodule

// File: rtl/serial_rx_align_chk.sv
module serial_rx_align_chk
  import serial_rx_pkg::*;
#(
  parameter int BIT_CLKS = 16,
  parameter int NBITS    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_strobe,
  input logic [NBITS-1:0] rx_data,
  input logic             rx_ready,
  input logic             irq_pulse,
  input logic             start_det,
  input logic             baud_tick,
  input logic             frame_done,
  input rx_state_t        state
);
  localparam int GW = $clog2(BIT_CLKS) + 2;
  localparam logic [GW-1:0] FULL_GAP  = GW'(BIT_CLKS - 1);
  localparam logic [GW-1:0] FIRST_GAP = GW'(first_tick_gap(BIT_CLKS) - 1);

  logic [GW-1:0] gap;
  logic          seen_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      seen_tick <= 1'b0;
    end else begin
      if (start_det || baud_tick) gap <= '0;
      else if (gap != '1)         gap <= gap + 1'b1;
      if (start_det)      seen_tick <= 1'b0;
      else if (baud_tick) seen_tick <= 1'b1;
    end
  end

  // R2: first tick comes half a period after start, later ones a full period apart
  a_r2_first_tick: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick && !seen_tick |-> gap == FIRST_GAP);
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick && seen_tick |-> gap == FULL_GAP);
  // R4: no start detection while a frame is ticking
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, baud_tick}));
  // R5: ready follows completion and holds until read
  a_r5_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_ready);
  a_r5_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rd_strobe |=> rx_ready);
  a_r5_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && rd_strobe && !frame_done |=> !rx_ready);
  // R6: single-cycle request, aligned with ready
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  a_r6_irq_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> rx_ready);
  a_r6_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq_pulse);
  // R7: buffer changes only at completion
  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_data));
endmodule

bind serial_rx_align serial_rx_align_chk #(.BIT_CLKS(BIT_CLKS), .NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rx_data(rx_data),
  .rx_ready(rx_ready), .irq_pulse(irq_pulse), .start_det(start_det),
  .baud_tick(baud_tick), .frame_done(frame_done), .state(state)
);

// File: tb/serial_rx_align_tb.sv
module serial_rx_align_tb;
  localparam int CLK_HZ = 1600;
  localparam int BAUD   = 100;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam int NB     = 8;
  localparam int FIRST  = DIV - DIV / 2;
  localparam int DONE_EL = FIRST + (NB + 1) * DIV;
  localparam int LAT    = 3 + DONE_EL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxd_in = 1'b1;
  logic          rd_strobe = 1'b0;
  logic [NB-1:0] rx_data;
  logic          rx_ready;
  logic          irq_pulse;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int start_cyc = 0;
  int last_lat = 0;
  int irq_cnt = 0;
  bit finished = 0;

  serial_rx_align #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .NBITS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_ready(rx_ready), .irq_pulse(irq_pulse)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  bit          m_s1 = 1, m_s2 = 1, m_busy = 0, m_rdy = 0, m_irq = 0;
  int          m_el = 0;
  bit [NB-1:0] m_sh = '0, m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_busy = 0; m_rdy = 0; m_irq = 0;
      m_el = 0; m_sh = '0; m_data = '0;
    end else begin
      bit samp;
      bit done;
      samp = m_s2;
      m_s2 = m_s1;
      m_s1 = rxd_in;
      done = 0;
      if (!m_busy) begin
        if (!samp) begin m_busy = 1; m_el = 0; end
      end else begin
        m_el++;
        if (m_el >= FIRST + DIV && m_el <= FIRST + NB * DIV && ((m_el - FIRST) % DIV) == 0)
          m_sh[(m_el - FIRST) / DIV - 1] = samp;
        if (m_el == DONE_EL) begin
          done = 1; m_busy = 0; m_data = m_sh;
        end
      end
      m_irq = done;
      m_rdy = done ? 1'b1 : (rd_strobe ? 1'b0 : m_rdy);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(rx_data == m_data, "R3 model rx_data", rx_data, m_data);
      chk(rx_ready == m_rdy, "R5 model rx_ready", rx_ready, m_rdy);
      chk(irq_pulse == m_irq, "R6 model irq_pulse", irq_pulse, m_irq);
      if (irq_pulse) begin
        irq_cnt++;
        last_lat = cyc - start_cyc;
      end
    end
  end

  // Called at a negedge; drives one frame, each cell DIV cycles long.
  task automatic send(input bit [NB-1:0] b, input bit stop_lvl, input bit glitch);
    start_cyc = cyc;
    rxd_in = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      if (glitch) begin
        rxd_in = ~b[i];
        @(negedge clk);
        rxd_in = b[i];
        repeat (DIV - 1) @(negedge clk);
      end else begin
        rxd_in = b[i];
        repeat (DIV) @(negedge clk);
      end
    end
    rxd_in = stop_lvl;
    repeat (DIV) @(negedge clk);
    rxd_in = 1'b1;
  endtask

  task automatic read_buf();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic report();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    report();
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    chk(rx_ready == 0 && irq_pulse == 0, "R1 reset flags", {rx_ready, irq_pulse}, 0);
    chk(rx_data == 0, "R1 reset data", rx_data, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_ready == 0 && irq_pulse == 0 && rx_data == 0, "R1 idle after reset",
        {rx_data, rx_ready, irq_pulse}, 0);

    // Plain frame, latency and data
    n0 = irq_cnt;
    send(8'hA5, 1'b1, 1'b0);
    chk(last_lat == LAT, "R2 completion latency", last_lat, LAT);
    chk(rx_data == 8'hA5, "R3 byte A5", rx_data, 8'hA5);
    chk(rx_ready == 1, "R5 ready after frame", rx_ready, 1);
    chk(irq_cnt == n0 + 1, "R6 one pulse per frame", irq_cnt - n0, 1);
    repeat (7) @(negedge clk);
    chk(rx_ready == 1, "R5 ready holds", rx_ready, 1);
    read_buf();
    chk(rx_ready == 0, "R5 read clears ready", rx_ready, 0);

    // LSB-first ordering with asymmetric pattern
    send(8'h01, 1'b1, 1'b0);
    chk(rx_data == 8'h01, "R3 LSB first 01", rx_data, 8'h01);
    read_buf();

    // Back-to-back, buffer holds old byte during next frame
    send(8'h00, 1'b1, 1'b0);
    chk(rx_data == 8'h00, "R3 byte 00", rx_data, 8'h00);
    fork
      send(8'hFF, 1'b1, 1'b0);
      begin
        repeat (5 * DIV) @(negedge clk);
        chk(rx_data == 8'h00, "R7 buffer held mid-frame", rx_data, 8'h00);
      end
    join
    chk(rx_data == 8'hFF, "R3 byte FF", rx_data, 8'hFF);
    chk(last_lat == LAT, "R2 back-to-back latency", last_lat, LAT);
    read_buf();

    // Glitches at every cell edge are ignored
    send(8'h3C, 1'b1, 1'b1);
    chk(rx_data == 8'h3C, "R4 glitch immunity", rx_data, 8'h3C);
    chk(last_lat == LAT, "R4 no restart latency", last_lat, LAT);
    read_buf();

    // Read strobe on completion edge: set wins
    fork
      send(8'h96, 1'b1, 1'b0);
      begin
        repeat (LAT - 1) @(negedge clk);
        read_buf();
        chk(rx_ready == 1, "R5 set wins over read", rx_ready, 1);
      end
    join
    chk(rx_data == 8'h96, "R3 byte 96", rx_data, 8'h96);
    read_buf();

    // Low stop cell: frame completes, low idle line starts a new frame
    n0 = irq_cnt;
    send(8'h5A, 1'b0, 1'b0);
    chk(rx_data == 8'h5A, "R8 low stop still completes", rx_data, 8'h5A);
    repeat (2 * LAT) @(negedge clk);
    chk(irq_cnt == n0 + 2, "R8 restart after low stop", irq_cnt - n0, 2);
    chk(rx_data == 8'hFF, "R8 restarted frame data", rx_data, 8'hFF);
    read_buf();
    repeat (4) @(negedge clk);
    chk(rx_ready == 0, "R5 final clear", rx_ready, 0);
    report();
  end
endmodule